// File: doc/BRIEF.md
# Command-Word Indirect Register Bridge

This block lets software reach the byte-wide internal registers of a two-wire serial bus engine through a single 64-bit command register. Software writes one word that carries a go flag, a direction flag, an operation code, a 3-bit register index and 32 data bits. The bridge waits a fixed number of cycles, performs the selected internal access and then drops the go flag. A read also places the register value in the low data bits of the word. Software learns that an access is finished by reading the word back until the go flag is 0.

The engine behind the bridge is modelled as a small register file. Index 3 is asymmetric: a write lands in the clock-control register, while a read returns the engine status, which enters on a port. The control and clock-control registers are brought out as ports, so the effect of a write can be seen directly.

Top module: `cmdword_reg_bridge`

## Requirements
- R1: After reset the command word reads all zeros, and the control and clock-control outputs are 0.
- R2: A write to the command word with bit 63 set is accepted, and bit 63 is 0 when read back. After the accepting clock edge, bit 63 reads 1 for exactly LATENCY cycles (default 3) and then reads 0.
- R3: While bit 63 reads 1, a write to the command word is ignored. The pending access completes as if no second write had happened.
- R4: With bits 60:57 equal to 6 and bit 56 equal to 0, completion writes data bits 7:0 into the register chosen by bits 34:32. The choices are 0 slave address, 1 data, 2 control, 3 clock control and 4 extended slave address.
- R5: With bits 60:57 equal to 6 and bit 56 equal to 1, completion replaces bits 31:0 with the zero-extended value of the chosen register. Reading index 3 returns the status input and never the clock-control register.
- R6: On completion, bits 62:32 of the word are returned unchanged. A write access also leaves bits 31:0 unchanged.
- R7: When bits 60:57 differ from 6, the access completes after the same latency, changes no register and leaves bits 31:0 unchanged.
- R8: Writing index 7 clears all five stored registers. Reads of indices 5, 6 and 7 return 0. Writes to indices 5 and 6 change nothing.
- R9: A command word written with bit 63 clear is stored as written and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_en | input | 1 | Write strobe for the command word |
| cmd_wr_word | input | 64 | Command word to write |
| cmd_rd_word | output | 64 | Current command word, polled by software |
| eng_status_i | input | REG_W | Engine status, returned by a read of index 3 |
| eng_ctl_o | output | REG_W | Stored control register |
| eng_clk_ctl_o | output | REG_W | Stored clock-control register |

## Verification
The main function is tried with a sweep that writes every index 0 to 7 with two complementary byte patterns and then reads every index back. This separates the stored registers from the reserved ones and shows that the index decode selects distinct targets. The status input is held at a value different from the clock-control contents, so a read of index 3 reveals which side of the shared index answered. Further patterns cover a non-6 operation code, a second write issued while an access is pending, and a word written with the go flag clear. The poll length is counted on every access.

// File: rtl/bridge_pkg.sv
// Package bridge_pkg
// Holds the field positions of the 64-bit command word and the register
// index names that are shared by every module of the bridge.
package bridge_pkg;
    localparam int CW_W       = 64;
    localparam int DATA_F_W   = 32;
    localparam int IDX_LSB    = 32;
    localparam int IDX_W      = 3;
    localparam int RD_BIT     = 56;
    localparam int OP_LSB     = 57;
    localparam int OP_W       = 4;
    localparam int GO_BIT     = 63;
    localparam logic [OP_W-1:0] OP_REG_ACCESS = 4'd6;

    typedef enum logic [IDX_W-1:0] {
        IX_SLV_ADDR  = 3'd0,
        IX_DATA      = 3'd1,
        IX_CTRL      = 3'd2,
        IX_CLK_STAT  = 3'd3,
        IX_SLV_ADDRX = 3'd4,
        IX_RSV5      = 3'd5,
        IX_RSV6      = 3'd6,
        IX_SOFT_RST  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/bridge_cmd_reg.sv
// Module bridge_cmd_reg
// Holds the command word and times each access.
// A write is accepted only while no access is pending.
// The go bit is cleared exactly LATENCY edges after the accepting edge.
// Assumes LATENCY >= 1.
module bridge_cmd_reg
    import bridge_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CW_W-1:0]     wr_word,
    input  logic                load_rd,
    input  logic [DATA_F_W-1:0] rd_val,
    output logic [CW_W-1:0]     word_q,
    output logic                done_o
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pending;

    // Pending means the go bit is set; completion happens when the count reaches 0.
    always_comb begin
        pending = word_q[GO_BIT];
        done_o  = pending && (cnt_q == '0);
    end

    // Accept new words when idle, count down the latency, finish the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (wr_en && !pending) begin
            word_q <= wr_word;
            cnt_q  <= CNT_W'(LATENCY - 1);
        end else if (done_o) begin
            word_q[GO_BIT] <= 1'b0;
            if (load_rd) begin
                word_q[DATA_F_W-1:0] <= rd_val;
            end
        end else if (pending) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: a pending word is frozen until its completion edge.
    a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !done_o) |=> $stable(word_q));

    // R2: the latency counter never exceeds its loaded value while pending.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (int'(cnt_q) < LATENCY));
endmodule

// File: rtl/bridge_decode.sv
// Module bridge_decode
// Turns a completing command into register-file strobes.
// Only the register-access operation code produces a strobe.
// Assumes done_i is high for one cycle per access.
module bridge_decode
    import bridge_pkg::*;
(
    input  logic            done_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            rd_i,
    output logic            acc_wr_o,
    output logic            acc_rd_o
);
    logic is_reg_op;

    // Split a completing register access into its write or read strobe.
    always_comb begin
        is_reg_op = (op_i == OP_REG_ACCESS);
        acc_wr_o  = done_i && is_reg_op && !rd_i;
        acc_rd_o  = done_i && is_reg_op && rd_i;
    end
endmodule

// File: rtl/bridge_regfile.sv
// Module bridge_regfile
// Models the engine registers that sit behind the bridge.
// It stores five registers at indices 0 to 4.
// Index 3 is the clock-control register on a write and the status input on a read.
// A write to index 7 clears every stored register.
// Indices 5 and 6 read as zero and ignore writes.
module bridge_regfile
    import bridge_pkg::*;
#(
    parameter int REG_W      = 8,
    parameter int NUM_STORED = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] status_i,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] ctl_o,
    output logic [REG_W-1:0] clk_ctl_o
);
    logic [REG_W-1:0] store_q [NUM_STORED];
    logic             soft_clr;

    // A write to the reset index is a clear of the whole file.
    always_comb begin
        soft_clr = wr_stb && (idx == IX_SOFT_RST);
    end

    for (genvar g = 0; g < NUM_STORED; g++) begin : g_reg
        // One stored register: cleared by reset or soft clear, loaded by a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                store_q[g] <= '0;
            end else if (wr_stb && (idx == IDX_W'(g))) begin
                store_q[g] <= wdata;
            end
        end

        // R9: without a write strobe no stored register changes.
        a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_stb |=> $stable(store_q[g]));
    end

    // Read mux: index 3 answers with status, reserved indices answer zero.
    always_comb begin
        case (idx)
            IX_SLV_ADDR:  rdata = store_q[0];
            IX_DATA:      rdata = store_q[1];
            IX_CTRL:      rdata = store_q[2];
            IX_CLK_STAT:  rdata = status_i;
            IX_SLV_ADDRX: rdata = store_q[4];
            default:      rdata = '0;
        endcase
    end

    // Bring the control and clock-control registers to the engine pins.
    always_comb begin
        ctl_o     = store_q[2];
        clk_ctl_o = store_q[3];
    end
endmodule

// File: rtl/cmdword_reg_bridge.sv
// Module cmdword_reg_bridge
// Top of the command-word bridge.
// Software writes a 64-bit word and polls its go bit.
// The bridge performs the indexed register access after LATENCY cycles.
// Assumes REG_W <= 32 so that a register fits the data field.
module cmdword_reg_bridge
    import bridge_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int LATENCY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_en,
    input  logic [63:0]      cmd_wr_word,
    output logic [63:0]      cmd_rd_word,
    input  logic [REG_W-1:0] eng_status_i,
    output logic [REG_W-1:0] eng_ctl_o,
    output logic [REG_W-1:0] eng_clk_ctl_o
);
    localparam int PAD_W = DATA_F_W - REG_W;

    logic [CW_W-1:0]     word_q;
    logic                done;
    logic                acc_wr;
    logic                acc_rd;
    logic [REG_W-1:0]    reg_rdata;
    logic [DATA_F_W-1:0] rd_val;

    // Zero-extend the selected register into the data field width.
    always_comb begin
        rd_val = {{PAD_W{1'b0}}, reg_rdata};
    end

    bridge_cmd_reg #(.LATENCY(LATENCY)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_wr_en),
        .wr_word (cmd_wr_word),
        .load_rd (acc_rd),
        .rd_val  (rd_val),
        .word_q  (word_q),
        .done_o  (done)
    );

    bridge_decode u_dec (
        .done_i   (done),
        .op_i     (word_q[OP_LSB +: OP_W]),
        .rd_i     (word_q[RD_BIT]),
        .acc_wr_o (acc_wr),
        .acc_rd_o (acc_rd)
    );

    bridge_regfile #(.REG_W(REG_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (acc_wr),
        .idx       (word_q[IDX_LSB +: IDX_W]),
        .wdata     (word_q[REG_W-1:0]),
        .status_i  (eng_status_i),
        .rdata     (reg_rdata),
        .ctl_o     (eng_ctl_o),
        .clk_ctl_o (eng_clk_ctl_o)
    );

    // Present the command word to software.
    always_comb begin
        cmd_rd_word = word_q;
    end

    // R5: a completed read of index 3 carries the status sampled at completion.
    a_r5_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && word_q[RD_BIT] && (word_q[OP_LSB +: OP_W] == OP_REG_ACCESS)
         && (word_q[IDX_LSB +: IDX_W] == IX_CLK_STAT))
        |=> (cmd_rd_word[REG_W-1:0] == $past(eng_status_i)));

    // R7: any other operation code leaves the data field untouched.
    a_r7_other_op: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (word_q[OP_LSB +: OP_W] != OP_REG_ACCESS))
        |=> $stable(cmd_rd_word[DATA_F_W-1:0]));

    // R2: completion always drops the go bit on the next edge.
    a_r2_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_rd_word[GO_BIT]);
endmodule

// File: tb/cmdword_reg_bridge_tb_top.sv
// Bench for cmdword_reg_bridge: sweeps writes and reads over all indices
// against an arithmetic model of the register file.
module cmdword_reg_bridge_tb_top;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [63:0] cmd_wr_word = '0;
    logic [63:0] cmd_rd_word;
    logic [7:0]  eng_status_i = 8'hC3;
    logic [7:0]  eng_ctl_o;
    logic [7:0]  eng_clk_ctl_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    logic [7:0] model [5];

    always #10 clk = ~clk;

    cmdword_reg_bridge #(.REG_W(8), .LATENCY(LAT)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr_en     (cmd_wr_en),
        .cmd_wr_word   (cmd_wr_word),
        .cmd_rd_word   (cmd_rd_word),
        .eng_status_i  (eng_status_i),
        .eng_ctl_o     (eng_ctl_o),
        .eng_clk_ctl_o (eng_clk_ctl_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Build a command word; side bits fill 62:61 and 55:35 to test pass-through.
    function automatic logic [63:0] mk(input logic go, input logic [3:0] op,
                                       input logic rd, input logic [2:0] idx,
                                       input logic [31:0] data);
        logic [63:0] w;
        w = 64'h0;
        w[63] = go;
        w[62:61] = 2'b10;
        w[60:57] = op;
        w[56] = rd;
        w[55:35] = 21'h15A3C;
        w[34:32] = idx;
        w[31:0] = data;
        return w;
    endfunction

    // Present one word for one cycle; returns at the negedge after the edge.
    task automatic send(input logic [63:0] w);
        cmd_wr_en = 1'b1;
        cmd_wr_word = w;
        @(negedge clk);
        cmd_wr_en = 1'b0;
    endtask

    // Count the samples during which the go bit still reads 1.
    task automatic poll(output int n);
        n = 0;
        while (cmd_rd_word[63] && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] exp_read(input int idx);
        if (idx == 3) return eng_status_i;
        if (idx < 5) return model[idx];
        return 8'h00;
    endfunction

    // Register access with latency (R2) and pass-through (R6) checks.
    task automatic do_write(input int idx, input logic [7:0] v);
        logic [63:0] w;
        int n;
        w = mk(1'b1, 4'd6, 1'b0, 3'(idx), {24'h0, v});
        send(w);
        poll(n);
        chk("R2 latency", 64'(n), 64'(LAT));
        chk("R6 write word", cmd_rd_word, w & ~(64'h1 << 63));
        if (idx < 5) model[idx] = v;
        if (idx == 7) for (int k = 0; k < 5; k++) model[k] = 8'h00;
    endtask

    task automatic do_read_chk(input int idx, input string tag);
        logic [63:0] w;
        logic [63:0] e;
        int n;
        w = mk(1'b1, 4'd6, 1'b1, 3'(idx), 32'hDEAD_BEEF);
        send(w);
        poll(n);
        chk("R2 latency", 64'(n), 64'(LAT));
        e = w & ~(64'h1 << 63);
        e[31:0] = {24'h0, exp_read(idx)};
        chk(tag, cmd_rd_word, e);
    endtask

    initial begin
        int n;
        logic [63:0] w;
        logic [7:0] pats [2];
        pats[0] = 8'h5A;
        pats[1] = 8'hA5;
        for (int k = 0; k < 5; k++) model[k] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 word", cmd_rd_word, 64'h0);
        chk("R1 ctl", 64'(eng_ctl_o), 64'h0);
        chk("R1 clkctl", 64'(eng_clk_ctl_o), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < 2; p++) begin
            // R4 / R8: write indices 0..6 with distinct values.
            for (int i = 0; i < 7; i++) do_write(i, pats[p] ^ 8'(i));
            chk("R4 ctl out", 64'(eng_ctl_o), 64'(model[2]));
            chk("R4 clkctl out", 64'(eng_clk_ctl_o), 64'(model[3]));
            // R5: read back every index; index 3 gives status, not clock control.
            for (int i = 0; i < 8; i++) do_read_chk(i, "R5 R8 read");
            eng_status_i = ~eng_status_i;
            do_read_chk(3, "R5 status changed");
            // R8: reset index clears everything.
            do_write(7, 8'hFF);
            chk("R8 ctl cleared", 64'(eng_ctl_o), 64'h0);
            chk("R8 clkctl cleared", 64'(eng_clk_ctl_o), 64'h0);
            for (int i = 0; i < 8; i++) do_read_chk(i, "R8 read after clear");
        end

        do_write(2, 8'h33);
        do_write(3, 8'h66);
        // R7: non-6 opcodes, write and read flavour.
        w = mk(1'b1, 4'd5, 1'b0, 3'd2, 32'h0000_0011);
        send(w);
        poll(n);
        chk("R7 latency", 64'(n), 64'(LAT));
        chk("R7 word", cmd_rd_word, w & ~(64'h1 << 63));
        chk("R7 ctl unchanged", 64'(eng_ctl_o), 64'h33);
        w = mk(1'b1, 4'd0, 1'b1, 3'd3, 32'h1234_5678);
        send(w);
        poll(n);
        chk("R7 read-op data kept", cmd_rd_word, w & ~(64'h1 << 63));
        chk("R7 clkctl unchanged", 64'(eng_clk_ctl_o), 64'h66);

        // R3: second write while pending is ignored.
        w = mk(1'b1, 4'd6, 1'b0, 3'd2, 32'h0000_0044);
        send(w);
        send(mk(1'b1, 4'd6, 1'b0, 3'd2, 32'h0000_0099));
        poll(n);
        chk("R3 busy poll", 64'(n), 64'(LAT - 1));
        chk("R3 word kept", cmd_rd_word, w & ~(64'h1 << 63));
        chk("R3 ctl", 64'(eng_ctl_o), 64'h44);

        // R9: word without go bit is stored but does nothing.
        w = mk(1'b0, 4'd6, 1'b0, 3'd2, 32'h0000_0077);
        send(w);
        chk("R9 stored", cmd_rd_word, w);
        repeat (LAT + 1) @(negedge clk);
        chk("R9 ctl unchanged", 64'(eng_ctl_o), 64'h44);
        chk("R9 word stable", cmd_rd_word, w);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule